// File: doc/BRIEF.md
# Interrupt Destination Mask Resolver

This block turns the destination of a single interrupt request into a delivery bitmask over a fixed set of local interrupt targets. Bit i of the mask stands for target slot i. Each slot describes one target: a populated flag, a flag for extended (32-bit) addressing, an 8-bit legacy ID, a 32-bit extended ID, an 8-bit legacy logical ID, a 4-bit legacy logical model selector, and a 32-bit extended logical ID. Legacy and extended targets can sit in the same set. Each kind reads broadcast and logical addresses by its own rules, and the results are merged into one mask.

A requester presents a 32-bit destination, a physical/logical flag, a 2-bit shorthand and its own slot index, and raises a strobe. The mask is computed from scratch for every request. It appears one clock later together with a single-cycle done pulse, and it then stays put until the next request.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand 1 sets only the requester's own slot bit, and only if that slot is populated. The destination is ignored.
- R2: Shorthand 2 sets the bit of every populated slot.
- R3: Shorthand 3 sets the bit of every populated slot except the requester's.
- R4: With shorthand 0, physical mode (logical flag 0) and destination 0xFFFFFFFF, every populated slot is selected, in either addressing kind.
- R5: With shorthand 0, logical mode and destination 0xFFFFFFFF, every populated extended slot is selected. Legacy slots are still judged by the legacy logical rules (R9 to R11) on the low byte 0xFF.
- R6: In physical mode, an extended slot matches when its 32-bit ID equals the whole destination. A legacy slot matches when its 8-bit ID equals destination bits [7:0].
- R7: In physical mode, a destination of exactly 0x000000FF also selects every populated legacy slot. An extended slot matches it only by ID.
- R8: In logical mode, an extended slot matches when destination bits [31:16] equal its extended logical ID bits [31:16] and the bitwise AND of bits [15:0] of the two values is nonzero.
- R9: In logical mode, a legacy slot with model selector 0xF (flat) matches when destination bits [7:0] ANDed with its logical ID is nonzero.
- R10: In logical mode, a legacy slot with model selector 0x0 (cluster) matches when destination bits [7:4] are 0xF or equal its logical ID bits [7:4], and destination bits [3:0] ANDed with its logical ID bits [3:0] is nonzero.
- R11: A legacy slot whose model selector is neither 0xF nor 0x0 never matches a logical destination.
- R12: An unpopulated slot's bit is never set, broadcasts included.
- R13: The mask is loaded on the clock edge after a strobed request, and done is high for exactly that one cycle per strobe. Without a strobe, done is low and the mask holds. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_valid | input | N_TGT | Slot populated flags |
| tgt_ext | input | N_TGT | Slot uses extended 32-bit addressing |
| tgt_lid | input | 8*N_TGT | Legacy physical IDs, slot i at [8i+7:8i] |
| tgt_xid | input | 32*N_TGT | Extended physical IDs, slot i at [32i+31:32i] |
| tgt_logid | input | 8*N_TGT | Legacy logical IDs |
| tgt_model | input | 4*N_TGT | Legacy logical model selector (0xF flat, 0x0 cluster) |
| tgt_xlog | input | 32*N_TGT | Extended logical IDs |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 32 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical |
| req_short | input | 2 | 0 destination, 1 self, 2 all, 3 all but self |
| req_src | input | clog2(N_TGT) | Requester's slot index |
| mask_out | output | N_TGT | Delivery mask, bit i for slot i |
| done | output | 1 | One-cycle pulse when mask_out is fresh |

## Verification
The target set mixes flat, cluster and unsupported-model legacy slots, extended slots whose IDs or logical IDs overlap legacy values, and one unpopulated slot. Physical IDs that agree only in the low byte separate 32-bit compares from 8-bit compares. Destination 0xFF is sent in both modes, and all-ones as well, which shows whether broadcast handling depends on the addressing kind. Logical destinations whose cluster nibble matches but whose member bits do not, or which match a flat ID only through high bits, tell the flat, cluster and extended rules apart. Shorthands are tried with a populated and an unpopulated requester, and back-to-back strobes and idle gaps probe the done pulse and the hold of the mask.

// File: rtl/idr_pkg.sv
package idr_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0]  MODEL_FLAT    = 4'hF;
  localparam logic [3:0]  MODEL_CLUSTER = 4'h0;
  localparam logic [3:0]  CLUSTER_ANY   = 4'hF;
  localparam logic [31:0] DEST_BCAST_X  = 32'hFFFF_FFFF;
  localparam logic [31:0] DEST_BCAST_L  = 32'h0000_00FF;

endpackage

// File: rtl/idr_slot_match.sv
module idr_slot_match
  import idr_pkg::*;
(
  input  logic [31:0] dest,
  input  logic        logical,
  input  logic        ext,
  input  logic [7:0]  lid,
  input  logic [31:0] xid,
  input  logic [7:0]  logid,
  input  logic [3:0]  model,
  input  logic [31:0] xlog,
  output logic        hit
);

  logic [7:0] dlow;
  logic       all_ones;
  logic       phys_hit;
  logic       xlog_hit;
  logic       llog_hit;

  assign dlow     = dest[7:0];
  assign all_ones = (dest == DEST_BCAST_X);

  // physical addressing
  always_comb begin
    if (all_ones) begin
      phys_hit = 1'b1;
    end else if (ext) begin
      phys_hit = (xid == dest);
    end else begin
      phys_hit = (lid == dlow) || (dest == DEST_BCAST_L);
    end
  end

  // extended logical addressing
  always_comb begin
    xlog_hit = all_ones ||
               ((dest[31:16] == xlog[31:16]) && (|(dest[15:0] & xlog[15:0])));
  end

  // legacy logical addressing
  always_comb begin
    case (model)
      MODEL_FLAT:    llog_hit = |(dlow & logid);
      MODEL_CLUSTER: llog_hit = ((dlow[7:4] == CLUSTER_ANY) ||
                                 (dlow[7:4] == logid[7:4])) &&
                                (|(dlow[3:0] & logid[3:0]));
      default:       llog_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!logical) begin
      hit = phys_hit;
    end else if (ext) begin
      hit = xlog_hit;
    end else begin
      hit = llog_hit;
    end
  end

endmodule

// File: rtl/idr_shorthand_sel.sv
module idr_shorthand_sel
  import idr_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [1:0]       short_sel,
  input  logic [IDXW-1:0]  src,
  input  logic [N_TGT-1:0] dest_hits,
  input  logic [N_TGT-1:0] populated,
  output logic [N_TGT-1:0] next_mask
);

  logic [N_TGT-1:0] self_onehot;
  logic [N_TGT-1:0] raw_mask;

  for (genvar gi = 0; gi < N_TGT; gi++) begin : g_self
    assign self_onehot[gi] = (src == IDXW'(gi));
  end

  always_comb begin
    case (shorthand_e'(short_sel))
      SH_DEST:   raw_mask = dest_hits;
      SH_SELF:   raw_mask = self_onehot;
      SH_ALL:    raw_mask = '1;
      SH_OTHERS: raw_mask = ~self_onehot;
      default:   raw_mask = '0;
    endcase
  end

  // an unpopulated slot is never addressed
  assign next_mask = raw_mask & populated;

endmodule

// File: rtl/idr_mask_reg.sv
module idr_mask_reg #(
  parameter int N_TGT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_TGT-1:0] mask_d,
  output logic [N_TGT-1:0] mask_q,
  output logic             done_q
);

  logic [N_TGT-1:0] mask_nxt;
  logic             done_nxt;

  always_comb begin
    mask_nxt = mask_q;
    if (load) begin
      mask_nxt = mask_d;
    end
    done_nxt = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      done_q <= done_nxt;
    end
  end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import idr_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_TGT-1:0]      tgt_valid,
  input  logic [N_TGT-1:0]      tgt_ext,
  input  logic [8*N_TGT-1:0]    tgt_lid,
  input  logic [32*N_TGT-1:0]   tgt_xid,
  input  logic [8*N_TGT-1:0]    tgt_logid,
  input  logic [4*N_TGT-1:0]    tgt_model,
  input  logic [32*N_TGT-1:0]   tgt_xlog,
  input  logic                  req_valid,
  input  logic [31:0]           req_dest,
  input  logic                  req_logical,
  input  logic [1:0]            req_short,
  input  logic [IDXW-1:0]       req_src,
  output logic [N_TGT-1:0]      mask_out,
  output logic                  done
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [N_TGT-1:0] dest_hits;
  logic [N_TGT-1:0] next_mask;

  for (genvar gi = 0; gi < N_TGT; gi++) begin : g_slot
    idr_slot_match u_match (
      .dest    (req_dest),
      .logical (req_logical),
      .ext     (tgt_ext[gi]),
      .lid     (tgt_lid[8*gi +: 8]),
      .xid     (tgt_xid[32*gi +: 32]),
      .logid   (tgt_logid[8*gi +: 8]),
      .model   (tgt_model[4*gi +: 4]),
      .xlog    (tgt_xlog[32*gi +: 32]),
      .hit     (dest_hits[gi])
    );
  end

  idr_shorthand_sel #(.N_TGT(N_TGT)) u_sel (
    .short_sel (req_short),
    .src       (req_src),
    .dest_hits (dest_hits),
    .populated (tgt_valid),
    .next_mask (next_mask)
  );

  idr_mask_reg #(.N_TGT(N_TGT)) u_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (req_valid),
    .mask_d (next_mask),
    .mask_q (mask_out),
    .done_q (done)
  );

  // R13: strobe yields a done pulse on the next cycle
  a_r13_done_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> done);

  // R13: no strobe, no done
  a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !done);

  // R13: mask holds between requests
  a_r13_mask_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> $stable(mask_out));

  // R12: only populated slots appear in a fresh mask
  a_r12_populated_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> ((mask_out & ~$past(tgt_valid)) == '0));

  // R2: all-targets shorthand equals the populated set
  a_r2_all_targets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_short == SH_ALL) |=> (mask_out == $past(tgt_valid)));

  // R1: self shorthand selects at most one slot
  a_r1_self_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_short == SH_SELF) |=> ($countones(mask_out) <= 1));

  // R3: all-but-self never includes the requester
  a_r3_excludes_src: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_short == SH_OTHERS) |=> !mask_out[$past(req_src)]);

  // R4: physical all-ones destination reaches every populated slot
  a_r4_phys_bcast: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_short == SH_DEST && !req_logical && (&req_dest))
      |=> (mask_out == $past(tgt_valid)));

  // R5: logical all-ones reaches every populated extended slot
  a_r5_log_bcast_ext: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_short == SH_DEST && req_logical && (&req_dest))
      |=> ((mask_out & $past(tgt_ext) & $past(tgt_valid)) ==
           ($past(tgt_ext) & $past(tgt_valid))));

endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;

  localparam int N = 8;
  localparam int IW = 3;

  logic              clk;
  logic              rst_n;
  logic [N-1:0]      tgt_valid;
  logic [N-1:0]      tgt_ext;
  logic [8*N-1:0]    tgt_lid;
  logic [32*N-1:0]   tgt_xid;
  logic [8*N-1:0]    tgt_logid;
  logic [4*N-1:0]    tgt_model;
  logic [32*N-1:0]   tgt_xlog;
  logic              req_valid;
  logic [31:0]       req_dest;
  logic              req_logical;
  logic [1:0]        req_short;
  logic [IW-1:0]     req_src;
  logic [N-1:0]      mask_out;
  logic              done;

  int checks;
  int errors;
  bit finished;

  irq_dest_resolver #(.N_TGT(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tgt_valid(tgt_valid), .tgt_ext(tgt_ext), .tgt_lid(tgt_lid),
    .tgt_xid(tgt_xid), .tgt_logid(tgt_logid), .tgt_model(tgt_model),
    .tgt_xlog(tgt_xlog), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_short(req_short), .req_src(req_src),
    .mask_out(mask_out), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {dest[31:0], logical, short[1:0], src[2:0], expected[7:0]}
  localparam int NV = 23;
  localparam logic [45:0] VEC [NV] = '{
    {32'h0000_0001, 1'b0, 2'd0, 3'd0, 8'h01},  // R6 legacy id
    {32'h0000_0123, 1'b0, 2'd0, 3'd0, 8'h04},  // R6 extended id
    {32'h0000_0102, 1'b0, 2'd0, 3'd0, 8'h02},  // R6 legacy low byte only
    {32'h0000_0006, 1'b0, 2'd0, 3'd0, 8'h40},  // R6 model ignored in physical
    {32'h0000_0005, 1'b0, 2'd0, 3'd0, 8'h00},  // R12 unpopulated id
    {32'h0000_00FF, 1'b0, 2'd0, 3'd0, 8'h5B},  // R7 legacy broadcast + ext id FF
    {32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0, 8'hDF},  // R4 physical all-ones
    {32'hFFFF_FFFF, 1'b1, 2'd0, 3'd0, 8'h9F},  // R5 logical all-ones
    {32'h0012_0008, 1'b1, 2'd0, 3'd0, 8'h04},  // R8 ext logical hit
    {32'h0012_0004, 1'b1, 2'd0, 3'd0, 8'h00},  // R8 cluster ok, member miss
    {32'h1000_0081, 1'b1, 2'd0, 3'd0, 8'h81},  // R8 + R9
    {32'h0000_0003, 1'b1, 2'd0, 3'd0, 8'h01},  // R9 flat
    {32'h0000_0012, 1'b1, 2'd0, 3'd0, 8'h02},  // R10 cluster 1
    {32'h0000_0011, 1'b1, 2'd0, 3'd0, 8'h01},  // R10 member miss, R9 flat hit
    {32'h0000_00F3, 1'b1, 2'd0, 3'd0, 8'h0B},  // R10 any-cluster
    {32'h0000_0021, 1'b1, 2'd0, 3'd0, 8'h09},  // R10 cluster 2
    {32'h0000_0006, 1'b1, 2'd0, 3'd0, 8'h00},  // R11 other model
    {32'h0000_00FE, 1'b1, 2'd0, 3'd0, 8'h02},  // R11 + R10
    {32'hFFFF_FFFF, 1'b0, 2'd1, 3'd3, 8'h08},  // R1 self
    {32'hFFFF_FFFF, 1'b0, 2'd1, 3'd5, 8'h00},  // R1 unpopulated self
    {32'h0000_0000, 1'b0, 2'd2, 3'd0, 8'hDF},  // R2 all
    {32'h0000_0000, 1'b1, 2'd3, 3'd2, 8'hDB},  // R3 all but self
    {32'h0000_0000, 1'b0, 2'd3, 3'd5, 8'hDF}   // R3 unpopulated self
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input bit v, input bit x, input logic [7:0] lid,
                          input logic [31:0] xid, input logic [7:0] lg,
                          input logic [3:0] md, input logic [31:0] xl);
    tgt_valid[i]        = v;
    tgt_ext[i]          = x;
    tgt_lid[8*i +: 8]   = lid;
    tgt_xid[32*i +: 32] = xid;
    tgt_logid[8*i +: 8] = lg;
    tgt_model[4*i +: 4] = md;
    tgt_xlog[32*i +: 32] = xl;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    set_slot(0, 1, 0, 8'h01, 32'h0,          8'h01, 4'hF, 32'h0);
    set_slot(1, 1, 0, 8'h02, 32'h0,          8'h12, 4'h0, 32'h0);
    set_slot(2, 1, 1, 8'h00, 32'h0000_0123,  8'h00, 4'h0, 32'h0012_0008);
    set_slot(3, 1, 0, 8'h03, 32'h0,          8'h21, 4'h0, 32'h0);
    set_slot(4, 1, 1, 8'h00, 32'h0000_00FF,  8'h00, 4'h0, 32'h000F_8000);
    set_slot(5, 0, 0, 8'h05, 32'h0,          8'hFF, 4'hF, 32'h0);
    set_slot(6, 1, 0, 8'h06, 32'h0,          8'h06, 4'h8, 32'h0);
    set_slot(7, 1, 1, 8'h00, 32'h0001_0007,  8'h00, 4'h0, 32'h1000_0080);
    req_valid   = 1'b0;
    req_dest    = '0;
    req_logical = 1'b0;
    req_short   = 2'd0;
    req_src     = '0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(mask_out == '0 && done == 1'b0, "R13 reset", {23'd0, done, mask_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R13 idle after reset", {31'd0, done}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      req_dest    = VEC[v][45:14];
      req_logical = VEC[v][13];
      req_short   = VEC[v][12:11];
      req_src     = VEC[v][10:8];
      req_valid   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(done == 1'b1, "R13 done", {31'd0, done}, 32'h1);
      chk(mask_out == VEC[v][7:0], $sformatf("vector %0d (R1..R12)", v),
          {24'd0, mask_out}, {24'd0, VEC[v][7:0]});
      @(negedge clk);
    end

    // R13: single pulse and hold while inputs move without a strobe
    req_dest = 32'hFFFF_FFFF; req_logical = 1'b0; req_short = 2'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_dest  = 32'h0000_0001;
    @(negedge clk);
    chk(done == 1'b0, "R13 done one cycle", {31'd0, done}, 32'h0);
    chk(mask_out == 8'hDF, "R13 mask hold", {24'd0, mask_out}, 32'hDF);
    repeat (3) @(negedge clk);
    chk(mask_out == 8'hDF, "R13 mask hold later", {24'd0, mask_out}, 32'hDF);

    // R13 + R6: back-to-back strobes, new mask each cycle
    req_valid = 1'b1;
    req_dest  = 32'h0000_0002;
    @(negedge clk);
    chk(done == 1'b1 && mask_out == 8'h02, "R13 back-to-back first",
        {23'd0, done, mask_out}, 32'h102);
    req_dest  = 32'h0001_0007;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1 && mask_out == 8'h80, "R13 back-to-back second (R6)",
        {23'd0, done, mask_out}, 32'h180);
    @(negedge clk);
    chk(done == 1'b0, "R13 pulse ends", {31'd0, done}, 32'h0);

    // R12: broadcast after slot 7 depopulated
    tgt_valid[7] = 1'b0;
    req_dest = 32'hFFFF_FFFF; req_logical = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mask_out == 8'h1F, "R12 logical bcast skips empty slot",
        {24'd0, mask_out}, 32'h1F);

    // R13: async reset clears mask
    rst_n = 1'b0;
    #1;
    chk(mask_out == '0 && done == 1'b0, "R13 reset clears",
        {23'd0, done, mask_out}, 32'h0);
    @(negedge clk);
    finish_run();
  end

endmodule